// File: doc/BRIEF.md
# Floppy Read Data Separator with Write Precompensation

This block sits between a floppy drive's serial read line and a disk controller. It runs entirely from one reference clock, where each clock period is one 62.5 ns tick of a 16 MHz reference. A window counter splits the read stream into bit cells. Each cell is a clock window followed by a data window. A pulse that lands in a data window becomes a 1 bit, and a cell whose data window stays empty becomes a 0 bit. Pulses that land in a clock window carry only timing. The same logic serves single-density (FM) and double-density (MFM) recording on both 8-inch and 5.25-inch drives. Two select inputs scale the window length.

The window counter follows the drive's speed. When an accepted pulse lands before the centre of its window, the counter takes one extra tick step. When it lands after the centre, the counter holds for one tick. Only one such correction is made per bit cell. A pulse too close to a window boundary is rejected and reported as a sync error.

The block also divides the reference down to the controller's operating clock. On the write side, each write pulse is delayed by a nominal amount. While precompensation is requested, the pulse leaves that many ticks earlier or later, as set by a 3-bit amount value.

Top module: `fdsep_top`

## Requirements
- R1: The window length in ticks is 16 for MFM on 8-inch drives, 32 for MFM on 5.25-inch drives, 32 for FM on 8-inch drives and 64 for FM on 5.25-inch drives. Use `sel_mfm`=1 for MFM and `sel_8in`=1 for 8-inch. After reset the block is in the clock window (`rd_win`=0). The window flips after every window length of ticks, so that the data window (`rd_win`=1) starts one window length after the clock window.
- R2: In FM the bench sends a clock pulse in every clock window. These pulses never set a data bit. A centred pulse in the data window yields `rd_data`=1, and no pulse yields 0.
- R3: In MFM, a centred pulse in the data window yields `rd_data`=1, and a cell with only a clock-window pulse yields 0.
- R4: `rd_valid` is high for exactly one cycle per bit cell. It rises the cycle after the last tick of the data window, together with `rd_data` for that cell.
- R5: An accepted pulse that lands before the window centre (centre = window length / 2) advances the counter by one extra tick. The current cell then ends one tick early.
- R6: An accepted pulse that lands after the window centre holds the counter for one tick. The current cell then ends one tick late.
- R7: At most one advance or hold is applied per bit cell. A second off-centre pulse in the same cell does not move the cell boundary.
- R8: A pulse within 2 ticks of either edge of a window raises `sync_err` for one cycle, in the cycle after its edge. It sets no data bit and makes no correction.
- R9: `fdc_clk` is low after reset and has a period of 8 ticks for 8-inch drives and 16 ticks for 5.25-inch drives, with a 50% duty cycle.
- R10: With precompensation off (`pc_en`=0), a write pulse reaches `wr_out`, one cycle wide, 8 ticks after its rising edge is sampled.
- R11: With `pc_en`=1, `pc_early` alone shortens the delay by `pc_amt` ticks and `pc_late` alone lengthens it by `pc_amt` ticks. Setting both or neither, or `pc_amt`=0, keeps the nominal 8.
- R12: While `wr_gate` is low, write pulses are ignored and `wr_out` stays low.
- R13: During and right after reset, `rd_valid`, `rd_data`, `sync_err`, `rd_win`, `wr_out` and `fdc_clk` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, one tick per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_pulse | input | 1 | Raw read pulse from the drive, rising edge taken |
| sel_mfm | input | 1 | 1 = MFM, 0 = FM |
| sel_8in | input | 1 | 1 = 8-inch drive, 0 = 5.25-inch drive |
| wr_gate | input | 1 | Controller is writing |
| wr_pulse | input | 1 | Raw write pulse, rising edge taken |
| pc_en | input | 1 | Precompensation requested for this track |
| pc_early | input | 1 | Shift the pulse earlier |
| pc_late | input | 1 | Shift the pulse later |
| pc_amt | input | 3 | Shift amount in ticks |
| rd_data | output | 1 | Separated data bit |
| rd_valid | output | 1 | Strobe for rd_data, once per cell |
| rd_win | output | 1 | Read window clock, high in the data window |
| sync_err | output | 1 | Pulse fell outside the window aperture |
| fdc_clk | output | 1 | Controller operating clock |
| wr_out | output | 1 | Precompensated write pulse |

## Verification
A wrong window phase or length shows up within one bit cell. `rd_valid` then rises on a cycle other than the computed cell end, and `rd_win` has the wrong level at the window midpoint. A faulty phase correction shifts the next `rd_valid` by one tick in the same cell as the off-centre pulse. A wrong aperture shows as `sync_err` or a lost data bit in the following cycle. Errors in the precompensation delay appear as `wr_out` rising on the wrong tick, at most 15 ticks after the write pulse.

// File: rtl/fdsep_pkg.sv
package fdsep_pkg;

  typedef enum logic {WIN_CLOCK = 1'b0, WIN_DATA = 1'b1} win_e;

  // Window length in ticks: base for MFM 8-inch, doubled for FM, doubled for 5.25-inch.
  function automatic int win_len(int base, logic mfm, logic eight);
    int w;
    w = base;
    if (!mfm)   w = w * 2;
    if (!eight) w = w * 2;
    return w;
  endfunction

  // Half period of the controller clock in ticks.
  function automatic int ctl_half(int half8, logic eight);
    return eight ? half8 : 2 * half8;
  endfunction

  // Write pulse delay in ticks; nominal is 2**amt_w so that the earliest shift stays positive.
  function automatic int wr_delay(int amt_w, logic active, logic early, logic late, int amt);
    int nom;
    nom = 1 << amt_w;
    if (active && early && !late) return nom - amt;
    if (active && late && !early) return nom + amt;
    return nom;
  endfunction

endpackage

// File: rtl/fdsep_window.sv
module fdsep_window #(
  parameter int WL_W  = 7,
  parameter int GUARD = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_evt,
  input  logic [WL_W-1:0] wlen,
  output logic            rd_data,
  output logic            rd_valid,
  output logic            rd_win,
  output logic            sync_err,
  output logic            nudge_adv,
  output logic            nudge_ret,
  output logic            cell_end
);
  import fdsep_pkg::*;

  localparam logic [WL_W-1:0] G = WL_W'(GUARD);

  logic [WL_W-1:0] phase;
  win_e            win;
  logic            nudged;
  logic            dbit;

  logic [WL_W-1:0] center;
  logic            last;
  logic            in_ap;
  logic            good_evt;
  logic            bad_evt;

  assign center   = wlen >> 1;
  assign last     = (phase >= wlen - 1'b1);
  assign in_ap    = (phase >= G) && (phase < wlen - G);
  assign good_evt = rd_evt && in_ap;
  assign bad_evt  = rd_evt && !in_ap;

  assign nudge_adv = good_evt && !nudged && (phase < center);
  assign nudge_ret = good_evt && !nudged && (phase > center);
  assign cell_end  = last && (win == WIN_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= '0;
      win      <= WIN_CLOCK;
      nudged   <= 1'b0;
      dbit     <= 1'b0;
      rd_data  <= 1'b0;
      rd_valid <= 1'b0;
      sync_err <= 1'b0;
    end else begin
      if (nudge_ret)      phase <= phase;
      else if (last)      phase <= '0;
      else if (nudge_adv) phase <= phase + WL_W'(2);
      else                phase <= phase + WL_W'(1);

      if (last) win <= (win == WIN_DATA) ? WIN_CLOCK : WIN_DATA;

      if (cell_end)                    nudged <= 1'b0;
      else if (nudge_adv || nudge_ret) nudged <= 1'b1;

      if (cell_end)                          dbit <= 1'b0;
      else if (good_evt && win == WIN_DATA)  dbit <= 1'b1;

      rd_valid <= cell_end;
      if (cell_end) rd_data <= dbit;
      sync_err <= bad_evt;
    end
  end

  assign rd_win = (win == WIN_DATA);

endmodule

// File: rtl/fdsep_ctlclk.sv
module fdsep_ctlclk #(
  parameter int HALF8 = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_8in,
  output logic fdc_clk
);
  localparam int CW = $clog2(2 * HALF8);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim = CW'(fdsep_pkg::ctl_half(HALF8, sel_8in) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      fdc_clk <= 1'b0;
    end else if (cnt >= lim) begin
      cnt     <= '0;
      fdc_clk <= ~fdc_clk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/fdsep_precomp.sv
module fdsep_precomp #(
  parameter int AMT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_evt,
  input  logic             wr_gate,
  input  logic             pc_en,
  input  logic             pc_early,
  input  logic             pc_late,
  input  logic [AMT_W-1:0] pc_amt,
  output logic             wr_out
);
  localparam int CW = AMT_W + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] dly;
  logic          busy;

  assign dly = CW'(fdsep_pkg::wr_delay(AMT_W, wr_gate && pc_en, pc_early, pc_late, int'(pc_amt)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      busy   <= 1'b0;
      wr_out <= 1'b0;
    end else begin
      wr_out <= 1'b0;
      if (!wr_gate) begin
        busy <= 1'b0;
      end else if (wr_evt) begin
        busy <= 1'b1;
        cnt  <= dly;
      end else if (busy) begin
        if (cnt == CW'(1)) begin
          wr_out <= 1'b1;
          busy   <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/fdsep_top.sv
module fdsep_top #(
  parameter int BASE_WIN = 16,
  parameter int GUARD    = 2,
  parameter int CTL_HALF = 4,
  parameter int AMT_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_pulse,
  input  logic             sel_mfm,
  input  logic             sel_8in,
  input  logic             wr_gate,
  input  logic             wr_pulse,
  input  logic             pc_en,
  input  logic             pc_early,
  input  logic             pc_late,
  input  logic [AMT_W-1:0] pc_amt,
  output logic             rd_data,
  output logic             rd_valid,
  output logic             rd_win,
  output logic             sync_err,
  output logic             fdc_clk,
  output logic             wr_out
);
  localparam int WL_W = $clog2(BASE_WIN * 4) + 1;

  logic            rd_q;
  logic            wr_q;
  logic            rd_evt;
  logic            wr_evt;
  logic [WL_W-1:0] wlen;
  logic            nudge_adv;
  logic            nudge_ret;
  logic            cell_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
    end else begin
      rd_q <= rd_pulse;
      wr_q <= wr_pulse;
    end
  end

  assign rd_evt = rd_pulse && !rd_q;
  assign wr_evt = wr_pulse && !wr_q;
  assign wlen   = WL_W'(fdsep_pkg::win_len(BASE_WIN, sel_mfm, sel_8in));

  fdsep_window #(.WL_W(WL_W), .GUARD(GUARD)) win_i (
    .clk(clk), .rst_n(rst_n), .rd_evt(rd_evt), .wlen(wlen),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_win(rd_win), .sync_err(sync_err),
    .nudge_adv(nudge_adv), .nudge_ret(nudge_ret), .cell_end(cell_end)
  );

  fdsep_ctlclk #(.HALF8(CTL_HALF)) ctl_i (
    .clk(clk), .rst_n(rst_n), .sel_8in(sel_8in), .fdc_clk(fdc_clk)
  );

  fdsep_precomp #(.AMT_W(AMT_W)) pc_i (
    .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .wr_gate(wr_gate),
    .pc_en(pc_en), .pc_early(pc_early), .pc_late(pc_late), .pc_amt(pc_amt),
    .wr_out(wr_out)
  );

endmodule

// File: rtl/fdsep_checks.sv
module fdsep_checks (
  input logic clk,
  input logic rst_n,
  input logic rd_evt,
  input logic rd_valid,
  input logic rd_win,
  input logic sync_err,
  input logic nudge_adv,
  input logic nudge_ret,
  input logic fdc_clk,
  input logic wr_gate,
  input logic wr_out
);

  a_r4_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  a_r4_valid_in_clock_win: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !rd_win);

  a_r7_no_back_to_back_nudge: assert property (@(posedge clk) disable iff (!rst_n)
    (nudge_adv || nudge_ret) |=> !(nudge_adv || nudge_ret));

  a_r8_err_from_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |-> $past(rd_evt));

  a_r8_err_no_nudge: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |-> !$past(nudge_adv || nudge_ret));

  a_r9_ctl_high_min: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fdc_clk) |=> fdc_clk);

  a_r12_wr_needs_gate: assert property (@(posedge clk) disable iff (!rst_n)
    wr_out |-> $past(wr_gate));

  a_r10_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_out |=> !wr_out);

endmodule

bind fdsep_top fdsep_checks chk_i (
  .clk(clk), .rst_n(rst_n), .rd_evt(rd_evt), .rd_valid(rd_valid), .rd_win(rd_win),
  .sync_err(sync_err), .nudge_adv(nudge_adv), .nudge_ret(nudge_ret),
  .fdc_clk(fdc_clk), .wr_gate(wr_gate), .wr_out(wr_out)
);

// File: tb/fdsep_tb.sv
module fdsep_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_pulse = 1'b0, sel_mfm = 1'b1, sel_8in = 1'b1;
  logic wr_gate = 1'b0, wr_pulse = 1'b0, pc_en = 1'b0, pc_early = 1'b0, pc_late = 1'b0;
  logic [2:0] pc_amt = 3'd0;
  logic rd_data, rd_valid, rd_win, sync_err, fdc_clk, wr_out;

  int checks = 0;
  int errors = 0;
  int ecount = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fdsep_top dut_i (
    .clk(clk), .rst_n(rst_n), .rd_pulse(rd_pulse), .sel_mfm(sel_mfm), .sel_8in(sel_8in),
    .wr_gate(wr_gate), .wr_pulse(wr_pulse), .pc_en(pc_en), .pc_early(pc_early),
    .pc_late(pc_late), .pc_amt(pc_amt), .rd_data(rd_data), .rd_valid(rd_valid),
    .rd_win(rd_win), .sync_err(sync_err), .fdc_clk(fdc_clk), .wr_out(wr_out)
  );

  // {mfm, eight_inch, 8-bit pattern, bit 0 first}
  localparam logic [9:0] VECS [6] = '{
    {1'b1, 1'b1, 8'hB5}, {1'b1, 1'b0, 8'h4C}, {1'b0, 1'b1, 8'h96},
    {1'b0, 1'b0, 8'h3A}, {1'b1, 1'b1, 8'h00}, {1'b0, 1'b1, 8'hFF}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    ecount++;
  endtask

  task automatic do_reset(input logic mfm, input logic eight);
    rst_n = 1'b0; rd_pulse = 1'b0; wr_pulse = 1'b0;
    sel_mfm = mfm; sel_8in = eight;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    ecount = 0;
  endtask

  task automatic pulse_at(input int n);
    while (ecount < n - 1) tick();
    rd_pulse = 1'b1;
    tick();
    rd_pulse = 1'b0;
  endtask

  task automatic wait_to(input int n);
    while (ecount < n) tick();
  endtask

  task automatic wr_case(input logic g, input logic en, input logic e, input logic l,
                         input logic [2:0] a, input int exp_k, input string req);
    int first;
    int hits;
    first = 0; hits = 0;
    wr_gate = g; pc_en = en; pc_early = e; pc_late = l; pc_amt = a;
    @(negedge clk);
    wr_pulse = 1'b1;
    @(negedge clk);
    wr_pulse = 1'b0;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (wr_out) begin
        hits++;
        if (first == 0) first = k;
      end
    end
    check(req, hits, (exp_k == 0) ? 0 : 1);
    check(req, first, exp_k);
    wr_gate = 1'b0; pc_en = 1'b0; pc_early = 1'b0; pc_late = 1'b0;
  endtask

  task automatic ctl_period(input logic eight, input int exp);
    logic prev;
    int cnt;
    do_reset(1'b1, eight);
    prev = fdc_clk;
    cnt = 0;
    while (!(fdc_clk && !prev) && cnt < 40) begin prev = fdc_clk; tick(); cnt++; end
    prev = fdc_clk;
    tick();
    cnt = 1;
    while (!(fdc_clk && !prev) && cnt < 40) begin prev = fdc_clk; tick(); cnt++; end
    check("R9 fdc_clk period", cnt, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R13: reset state
    repeat (3) @(negedge clk);
    check("R13 rd_valid", rd_valid, 0);
    check("R13 sync_err", sync_err, 0);
    check("R13 rd_win", rd_win, 0);
    check("R13 wr_out", wr_out, 0);
    check("R13 fdc_clk", fdc_clk, 0);
    check("R13 rd_data", rd_data, 0);

    // R1, R2, R3, R4: vector walk with centred pulses
    foreach (VECS[v]) begin
      logic m, e;
      logic [7:0] pat;
      int w;
      m = VECS[v][9]; e = VECS[v][8]; pat = VECS[v][7:0];
      w = 16 * (m ? 1 : 2) * (e ? 1 : 2);
      do_reset(m, e);
      for (int n = 1; n <= 16 * w; n++) begin
        int p, c;
        logic inwin, clkp;
        p = (n - 1) % w;
        inwin = (((n - 1) / w) % 2) == 1;
        c = (n - 1) / (2 * w);
        clkp = m ? (!pat[c] && !((c == 0) ? 1'b0 : pat[c-1])) : 1'b1;
        rd_pulse = (p == w / 2) && (inwin ? pat[c] : clkp);
        tick();
        rd_pulse = 1'b0;
        if (n % (2 * w) == 0) begin
          check(m ? "R3 R4 rd_valid" : "R2 R4 rd_valid", rd_valid, 1);
          check(m ? "R3 rd_data" : "R2 rd_data", rd_data, pat[n/(2*w)-1]);
          check("R1 rd_win at cell end", rd_win, 0);
        end else begin
          if (rd_valid) check("R4 rd_valid off cell end", rd_valid, 0);
          if (n % (2 * w) == w) check("R1 rd_win data window", rd_win, 1);
        end
        if (sync_err) check("R8 no sync_err on centred pulse", sync_err, 0);
      end
    end

    // R5: early pulse in data window advances cell end to tick 31
    do_reset(1'b1, 1'b1);
    pulse_at(22);
    wait_to(30); check("R5 no valid yet", rd_valid, 0);
    wait_to(31); check("R5 valid one early", rd_valid, 1); check("R5 data", rd_data, 1);

    // R6: late pulse holds, cell end moves to tick 33
    do_reset(1'b1, 1'b1);
    pulse_at(28);
    wait_to(32); check("R6 no valid at nominal", rd_valid, 0);
    wait_to(33); check("R6 valid one late", rd_valid, 1); check("R6 data", rd_data, 1);

    // R7: two early pulses in one cell, only the first moves the boundary
    do_reset(1'b1, 1'b1);
    pulse_at(6);
    pulse_at(21);
    wait_to(29); check("R7 no second advance", rd_valid, 0);
    wait_to(31); check("R7 valid after one advance", rd_valid, 1); check("R7 data", rd_data, 1);

    // R8: pulse inside guard band of data window
    do_reset(1'b1, 1'b1);
    pulse_at(18);
    check("R8 sync_err raised", sync_err, 1);
    wait_to(19); check("R8 sync_err one cycle", sync_err, 0);
    wait_to(32); check("R8 valid at nominal end", rd_valid, 1); check("R8 data not taken", rd_data, 0);

    // R9: controller clock periods
    ctl_period(1'b1, 8);
    ctl_period(1'b0, 16);

    // R10, R11, R12: write precompensation
    do_reset(1'b1, 1'b1);
    wr_case(1, 0, 1, 0, 3'd5, 8, "R10 precomp off");
    wr_case(1, 1, 0, 0, 3'd5, 8, "R10 no direction");
    wr_case(1, 1, 1, 0, 3'd3, 5, "R11 early 3");
    wr_case(1, 1, 0, 1, 3'd7, 15, "R11 late 7");
    wr_case(1, 1, 1, 1, 3'd4, 8, "R11 both set");
    wr_case(1, 1, 0, 1, 3'd0, 8, "R11 amount zero");
    wr_case(1, 1, 1, 0, 3'd7, 1, "R11 early 7");
    wr_case(0, 1, 1, 0, 3'd2, 0, "R12 gate low");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule